// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits behind the bus interface of a NOR flash device. It turns single-cycle write strobes into command pulses for the program and erase engines. Commands follow the usual unlock-key protocol: a fixed pair of key writes, then a code write, and for erase a second key pair and a final code. The decoder supports word addressing and byte addressing. In byte addressing the extra low address bit joins the key compare.

The decoder tracks an operating mode: read, identification, bypass, engine busy (program or chip erase), block erase, and erase suspended. In bypass, a program needs only two writes. While an engine runs, writes are filtered. Suspend, resume and extra block selections are passed on while a block erase is active. The engines report back through a busy input and a suspended input. In identification mode the block also answers read strobes with the vendor code, the device code, or the protection state of the addressed block.

Top module: `flash_cmd_decoder`

## Requirements
- R1: The unlock keys are word address 555h then 2AAh with data AAh then 55h in word mode. In byte mode they are word address 555h with the low byte bit 0, then word address 2AAh with the low byte bit 1. Keys, then code A0h at the first key address, then any address and data produce a one-cycle `cmd_prog` with that address, byte bit and full 16-bit data on `cmd_addr`, `cmd_lsb` and `cmd_data`, and `mode_o` becomes 3 (busy).
- R2: Keys then 90h at the first key address set `mode_o` to 1. In that mode a read strobe answers one cycle later with `id_valid` high and `id_data` chosen by read address bits [1:0]: 00 gives 0020h, 01 gives the device code parameter, 10 gives 0001h if the protect bit indexed by address bits [16:12] is set and 0000h otherwise, 11 gives 0000h. Outside that mode `id_valid` stays low.
- R3: A single write of F0h to any address, or the keys followed by F0h, gives `cmd_reset` and returns `mode_o` to the resting mode: read (0), bypass (2) or suspended (5).
- R4: Keys, 80h, keys again, then 10h at the first key address gives `cmd_chip` and `mode_o` 3. Ending instead with 30h at any address gives `cmd_block` with that address and `mode_o` 4.
- R5: A write that breaks a sequence gives no pulse and returns to the resting mode (read unless bypass or suspended).
- R6: Only word address bits [10:0] (plus the byte bit in byte mode) and data bits [7:0] take part in decoding.
- R7: In mode 3 all writes are ignored. On a falling edge of `busy_i` the mode returns to the resting mode.
- R8: In mode 4, B0h gives `cmd_susp`, 30h gives another `cmd_block`, F0h gives `cmd_reset` and mode 0, and other writes are ignored. A falling edge of `busy_i` gives mode 0. A high `susp_i` gives mode 5.
- R9: In mode 5, a single 30h gives `cmd_resume` and mode 4. Program and identification work as in read mode and come back to mode 5. The erase prefix and the bypass code are rejected as a broken sequence.
- R10: Keys then 20h gives bypass, mode 2. There, A0h then address/data gives `cmd_prog` and, after busy, mode 2 again. F0h gives `cmd_reset` and stays in mode 2. 90h then 00h gives mode 0. Any other write stays in mode 2.
- R11: After reset `mode_o` is 0 and no command is pulsed. At most one command pulse is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_mode | input | 1 | 1 selects byte addressing |
| wr_stb | input | 1 | One-cycle write strobe |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_lsb | input | 1 | Low byte address bit (byte mode) |
| wr_data | input | 16 | Write data |
| busy_i | input | 1 | Engine running |
| susp_i | input | 1 | Engine has suspended an erase |
| rd_stb | input | 1 | Identification read strobe |
| rd_addr | input | ADDR_W | Identification read address |
| prot_i | input | 2**(ADDR_W-12) | Protect bit per 4K-word block |
| cmd_reset | output | 1 | Reset command pulse |
| cmd_prog | output | 1 | Program command pulse |
| cmd_chip | output | 1 | Chip erase command pulse |
| cmd_block | output | 1 | Block erase select pulse |
| cmd_susp | output | 1 | Suspend command pulse |
| cmd_resume | output | 1 | Resume command pulse |
| cmd_addr | output | ADDR_W | Address captured with program or block select |
| cmd_lsb | output | 1 | Byte bit captured with the address |
| cmd_data | output | 16 | Program data |
| mode_o | output | 3 | Mode: 0 read, 1 identification, 2 bypass, 3 busy, 4 block erase, 5 suspended |
| id_valid | output | 1 | Identification answer valid |
| id_data | output | 16 | Identification answer |

## Verification
The hardest case to reach is a program issued from inside an erase suspension, which must come back to suspension and not to read. To get there, the stimulus starts a block erase, sends a suspend, and raises `susp_i`. It then runs a full program sequence and a busy pulse, and also tries the rejected erase prefix, before it resumes. Mismatch handling is swept over every data byte at the first key address. The identification answer is swept over all 32 protect bits.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  typedef enum logic [2:0] {
    M_READ   = 3'd0,
    M_ASEL   = 3'd1,
    M_BYPASS = 3'd2,
    M_PROG   = 3'd3,
    M_ERASE  = 3'd4,
    M_SUSP   = 3'd5
  } mode_e;

  typedef enum logic [1:0] {H_READ, H_BYP, H_SUSP} home_e;

  typedef enum logic [2:0] {
    S_IDLE, S_U1, S_U2, S_PD, S_E1, S_E2, S_E3, S_BR
  } seq_e;

  localparam logic [7:0] C_KEY1  = 8'hAA;
  localparam logic [7:0] C_KEY2  = 8'h55;
  localparam logic [7:0] C_ASEL  = 8'h90;
  localparam logic [7:0] C_PROG  = 8'hA0;
  localparam logic [7:0] C_BYP   = 8'h20;
  localparam logic [7:0] C_ERS   = 8'h80;
  localparam logic [7:0] C_CHIP  = 8'h10;
  localparam logic [7:0] C_BLK   = 8'h30;
  localparam logic [7:0] C_RST   = 8'hF0;
  localparam logic [7:0] C_SUSP  = 8'hB0;
  localparam logic [7:0] C_BYX   = 8'h00;

  typedef struct packed {
    logic rst;
    logic prog;
    logic chip;
    logic blk;
    logic susp;
    logic res;
  } cmd_t;

  function automatic mode_e rest_mode(home_e h);
    case (h)
      H_BYP:   return M_BYPASS;
      H_SUSP:  return M_SUSP;
      default: return M_READ;
    endcase
  endfunction
endpackage

// File: rtl/fcd_key_match.sv
module fcd_key_match #(
  parameter int KEY_BITS = 11,
  parameter logic [KEY_BITS-1:0] KEY_A = 11'h555,
  parameter logic [KEY_BITS-1:0] KEY_B = 11'h2AA
) (
  input  logic                byte_mode,
  input  logic [KEY_BITS-1:0] addr,
  input  logic                lsb,
  output logic                hit_a,
  output logic                hit_b
);
  // Byte addressing shifts each key left by one; the first key ends in 0,
  // the second in 1, so the extra bit is checked only in byte mode.
  localparam logic LSB_A = 1'b0;
  localparam logic LSB_B = 1'b1;

  always_comb begin
    hit_a = (addr == KEY_A) && (!byte_mode || (lsb == LSB_A));
    hit_b = (addr == KEY_B) && (!byte_mode || (lsb == LSB_B));
  end
endmodule

// File: rtl/fcd_seq.sv
module fcd_seq
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_lsb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              hit_a,
  input  logic              hit_b,
  input  logic              busy_i,
  input  logic              susp_i,
  output cmd_t              cmd_o,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              cmd_lsb,
  output logic [DATA_W-1:0] cmd_data,
  output mode_e             mode_o
);
  mode_e mode_q, mode_d;
  home_e home_q, home_d;
  seq_e  seq_q,  seq_d;
  cmd_t  cmd_q,  cmd_d;
  logic  busy_q;
  logic  cap_en;
  logic  mis;
  logic  busy_fall;
  logic [7:0] dbyte;
  logic [ADDR_W-1:0] caddr_q;
  logic              clsb_q;
  logic [DATA_W-1:0] cdata_q;

  assign dbyte     = wr_data[7:0];
  assign busy_fall = busy_q & ~busy_i;

  always_comb begin
    mode_d = mode_q;
    home_d = home_q;
    seq_d  = seq_q;
    cmd_d  = '0;
    cap_en = 1'b0;
    mis    = 1'b0;
    case (mode_q)
      M_PROG: begin
        if (busy_fall) mode_d = rest_mode(home_q);
      end
      M_ERASE: begin
        if (busy_fall) begin
          mode_d = M_READ;
          home_d = H_READ;
        end else if (susp_i) begin
          mode_d = M_SUSP;
          home_d = H_SUSP;
        end else if (wr_stb) begin
          if (dbyte == C_SUSP) begin
            cmd_d.susp = 1'b1;
          end else if (dbyte == C_RST) begin
            cmd_d.rst = 1'b1;
            mode_d    = M_READ;
            home_d    = H_READ;
          end else if (dbyte == C_BLK) begin
            cmd_d.blk = 1'b1;
            cap_en    = 1'b1;
          end
        end
      end
      M_BYPASS: begin
        if (wr_stb) begin
          case (seq_q)
            S_PD: begin
              cmd_d.prog = 1'b1;
              cap_en     = 1'b1;
              mode_d     = M_PROG;
              seq_d      = S_IDLE;
            end
            S_BR: begin
              seq_d = S_IDLE;
              if (dbyte == C_BYX) begin
                mode_d = M_READ;
                home_d = H_READ;
              end
            end
            default: begin
              seq_d = S_IDLE;
              if (dbyte == C_PROG)      seq_d = S_PD;
              else if (dbyte == C_ASEL) seq_d = S_BR;
              else if (dbyte == C_RST)  cmd_d.rst = 1'b1;
            end
          endcase
        end
      end
      default: begin
        if (wr_stb) begin
          case (seq_q)
            S_IDLE: begin
              if (hit_a && dbyte == C_KEY1) begin
                seq_d = S_U1;
              end else if (dbyte == C_RST) begin
                cmd_d.rst = 1'b1;
                mode_d    = rest_mode(home_q);
              end else if (mode_q == M_SUSP && dbyte == C_BLK) begin
                cmd_d.res = 1'b1;
                mode_d    = M_ERASE;
                home_d    = H_READ;
              end else begin
                mis = 1'b1;
              end
            end
            S_U1: begin
              if (hit_b && dbyte == C_KEY2) seq_d = S_U2;
              else mis = 1'b1;
            end
            S_U2: begin
              if (dbyte == C_RST) begin
                cmd_d.rst = 1'b1;
                seq_d     = S_IDLE;
                mode_d    = rest_mode(home_q);
              end else if (hit_a && dbyte == C_ASEL) begin
                seq_d  = S_IDLE;
                mode_d = M_ASEL;
              end else if (hit_a && dbyte == C_PROG) begin
                seq_d = S_PD;
              end else if (hit_a && dbyte == C_BYP && home_q == H_READ) begin
                seq_d  = S_IDLE;
                mode_d = M_BYPASS;
                home_d = H_BYP;
              end else if (hit_a && dbyte == C_ERS && home_q == H_READ) begin
                seq_d = S_E1;
              end else begin
                mis = 1'b1;
              end
            end
            S_PD: begin
              cmd_d.prog = 1'b1;
              cap_en     = 1'b1;
              mode_d     = M_PROG;
              seq_d      = S_IDLE;
            end
            S_E1: begin
              if (hit_a && dbyte == C_KEY1) seq_d = S_E2;
              else mis = 1'b1;
            end
            S_E2: begin
              if (hit_b && dbyte == C_KEY2) seq_d = S_E3;
              else mis = 1'b1;
            end
            S_E3: begin
              if (hit_a && dbyte == C_CHIP) begin
                cmd_d.chip = 1'b1;
                mode_d     = M_PROG;
                home_d     = H_READ;
                seq_d      = S_IDLE;
              end else if (dbyte == C_BLK) begin
                cmd_d.blk = 1'b1;
                cap_en    = 1'b1;
                mode_d    = M_ERASE;
                seq_d     = S_IDLE;
              end else begin
                mis = 1'b1;
              end
            end
            default: mis = 1'b1;
          endcase
          if (mis) begin
            seq_d  = S_IDLE;
            mode_d = rest_mode(home_q);
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= M_READ;
      home_q <= H_READ;
      seq_q  <= S_IDLE;
      cmd_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      home_q <= home_d;
      seq_q  <= seq_d;
      cmd_q  <= cmd_d;
      busy_q <= busy_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      caddr_q <= '0;
      clsb_q  <= 1'b0;
      cdata_q <= '0;
    end else if (cap_en) begin
      caddr_q <= wr_addr;
      clsb_q  <= wr_lsb;
      cdata_q <= wr_data;
    end
  end

  assign cmd_o    = cmd_q;
  assign cmd_addr = caddr_q;
  assign cmd_lsb  = clsb_q;
  assign cmd_data = cdata_q;
  assign mode_o   = mode_q;

  // R11: never two commands in one cycle
  assert_one_cmd_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmd_q));
  // R1: a program pulse coincides with the busy mode
  assert_prog_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_q.prog |-> mode_q == M_PROG);
  // R7: busy mode swallows every write
  assert_prog_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_PROG) |=> (cmd_q == '0));
  // R4: a block select leaves the decoder in block-erase mode
  assert_block_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_q.blk |-> mode_q == M_ERASE);
  // R9: resume only comes out of suspension
  assert_resume_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_q.res |-> $past(mode_q) == M_SUSP);
  // R3: a reset lands in a resting mode
  assert_reset_rest_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_q.rst |-> (mode_q == M_READ || mode_q == M_BYPASS || mode_q == M_SUSP));
endmodule

// File: rtl/fcd_id_read.sv
module fcd_id_read #(
  parameter int ADDR_W   = 17,
  parameter int BLK_LSB  = 12,
  parameter logic [15:0] MFR_CODE = 16'h0020,
  parameter logic [15:0] DEV_CODE = 16'h0051,
  localparam int BLK_W   = ADDR_W - BLK_LSB,
  localparam int NBLK    = 1 << BLK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              asel,
  input  logic              rd_stb,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [NBLK-1:0]   prot_i,
  output logic              id_valid,
  output logic [15:0]       id_data
);
  logic [BLK_W-1:0]     blk_idx;
  logic [BLK_LSB-3:0]   unused_mid;
  logic                 valid_d;
  logic [15:0]          data_d;
  logic                 valid_q;
  logic [15:0]          data_q;

  assign blk_idx    = rd_addr[ADDR_W-1:BLK_LSB];
  assign unused_mid = rd_addr[BLK_LSB-1:2];
  assign valid_d    = rd_stb & asel;

  always_comb begin
    case (rd_addr[1:0])
      2'b00:   data_d = MFR_CODE;
      2'b01:   data_d = DEV_CODE;
      2'b10:   data_d = {15'd0, prot_i[blk_idx]};
      default: data_d = 16'h0000;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= valid_d;
      if (valid_d) data_q <= data_d;
    end
  end

  assign id_valid = valid_q;
  assign id_data  = data_q;

  // R2: answers appear only for strobes made in identification mode
  assert_id_asel_R2: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> $past(asel) && $past(rd_stb));
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int BLK_LSB  = 12,
  parameter logic [15:0] DEV_CODE = 16'h0051,
  localparam int DATA_W  = 16,
  localparam int KEY_BITS = 11,
  localparam int NBLK    = 1 << (ADDR_W - BLK_LSB)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_mode,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_lsb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              busy_i,
  input  logic              susp_i,
  input  logic              rd_stb,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [NBLK-1:0]   prot_i,
  output logic              cmd_reset,
  output logic              cmd_prog,
  output logic              cmd_chip,
  output logic              cmd_block,
  output logic              cmd_susp,
  output logic              cmd_resume,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              cmd_lsb,
  output logic [DATA_W-1:0] cmd_data,
  output logic [2:0]        mode_o,
  output logic              id_valid,
  output logic [15:0]       id_data
);
  logic  hit_a, hit_b;
  cmd_t  cmd;
  mode_e mode;

  fcd_key_match #(.KEY_BITS(KEY_BITS)) u_keys (
    .byte_mode (byte_mode),
    .addr      (wr_addr[KEY_BITS-1:0]),
    .lsb       (wr_lsb),
    .hit_a     (hit_a),
    .hit_b     (hit_b)
  );

  fcd_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_stb   (wr_stb),
    .wr_addr  (wr_addr),
    .wr_lsb   (wr_lsb),
    .wr_data  (wr_data),
    .hit_a    (hit_a),
    .hit_b    (hit_b),
    .busy_i   (busy_i),
    .susp_i   (susp_i),
    .cmd_o    (cmd),
    .cmd_addr (cmd_addr),
    .cmd_lsb  (cmd_lsb),
    .cmd_data (cmd_data),
    .mode_o   (mode)
  );

  fcd_id_read #(.ADDR_W(ADDR_W), .BLK_LSB(BLK_LSB), .DEV_CODE(DEV_CODE)) u_id (
    .clk      (clk),
    .rst_n    (rst_n),
    .asel     (mode == M_ASEL),
    .rd_stb   (rd_stb),
    .rd_addr  (rd_addr),
    .prot_i   (prot_i),
    .id_valid (id_valid),
    .id_data  (id_data)
  );

  assign cmd_reset  = cmd.rst;
  assign cmd_prog   = cmd.prog;
  assign cmd_chip   = cmd.chip;
  assign cmd_block  = cmd.blk;
  assign cmd_susp   = cmd.susp;
  assign cmd_resume = cmd.res;
  assign mode_o     = mode;
endmodule

// File: tb/tb_flash_cmd_decoder.sv
module tb_flash_cmd_decoder;
  localparam int ADDR_W = 17;
  localparam logic [15:0] DEV = 16'h0051;
  localparam logic [31:0] PROT = 32'hA5C3_1E69;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic byte_mode = 1'b0, wr_stb = 1'b0, wr_lsb = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0;
  logic busy_i = 1'b0, susp_i = 1'b0, rd_stb = 1'b0;
  logic [31:0] prot_i = PROT;
  logic cmd_reset, cmd_prog, cmd_chip, cmd_block, cmd_susp, cmd_resume;
  logic [ADDR_W-1:0] cmd_addr;
  logic cmd_lsb;
  logic [15:0] cmd_data;
  logic [2:0] mode_o;
  logic id_valid;
  logic [15:0] id_data;

  int checks = 0, errors = 0;
  logic [5:0] pv;  // {reset,prog,chip,block,susp,resume}
  bit done = 0;

  always #5 clk = ~clk;

  flash_cmd_decoder #(.ADDR_W(ADDR_W), .DEV_CODE(DEV)) dut (
    .clk, .rst_n, .byte_mode, .wr_stb, .wr_addr, .wr_lsb, .wr_data,
    .busy_i, .susp_i, .rd_stb, .rd_addr, .prot_i,
    .cmd_reset, .cmd_prog, .cmd_chip, .cmd_block, .cmd_susp, .cmd_resume,
    .cmd_addr, .cmd_lsb, .cmd_data, .mode_o, .id_valid, .id_data);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [ADDR_W-1:0] a, logic l, logic [15:0] d);
    @(negedge clk);
    wr_stb = 1'b1; wr_addr = a; wr_lsb = l; wr_data = d;
    @(negedge clk);
    wr_stb = 1'b0;
    pv = {cmd_reset, cmd_prog, cmd_chip, cmd_block, cmd_susp, cmd_resume};
  endtask

  task automatic keys(bit bm);
    wr(17'h00555, 1'b0, 16'h00AA);
    wr(17'h002AA, bm, 16'h0055);
  endtask

  task automatic busy_pulse();
    @(negedge clk); busy_i = 1'b1;
    repeat (2) @(negedge clk);
    busy_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd(logic [ADDR_W-1:0] a);
    @(negedge clk); rd_stb = 1'b1; rd_addr = a;
    @(negedge clk); rd_stb = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 mode", mode_o, 0);
    chk("R11 pulses", {cmd_reset, cmd_prog, cmd_chip, cmd_block, cmd_susp, cmd_resume}, 0);

    // R1 word program
    keys(0); wr(17'h00555, 0, 16'h00A0); wr(17'h12345, 1, 16'hBEEF);
    chk("R1 prog pulse", pv, 6'b010000);
    chk("R1 addr", cmd_addr, 17'h12345);
    chk("R1 data", cmd_data, 16'hBEEF);
    chk("R1 mode", mode_o, 3);
    // R7 writes ignored while busy
    wr(17'h0, 0, 16'h00F0);
    chk("R7 ignore pulse", pv, 0);
    chk("R7 ignore mode", mode_o, 3);
    busy_pulse();
    chk("R7 busy end", mode_o, 0);

    // R1 byte-mode program
    byte_mode = 1'b1;
    keys(1); wr(17'h00555, 0, 16'h00A0); wr(17'h00777, 1, 16'h5A5A);
    chk("R1 byte prog", pv, 6'b010000);
    chk("R1 byte lsb", cmd_lsb, 1);
    busy_pulse();
    // R6 byte bit matters in byte mode
    wr(17'h00555, 1, 16'h00AA); wr(17'h002AA, 1, 16'h0055); wr(17'h00555, 0, 16'h00A0);
    wr(17'h00100, 0, 16'h1111);
    chk("R6 byte bit key", pv, 0);
    chk("R6 byte bit mode", mode_o, 0);
    byte_mode = 1'b0;

    // R6 upper address and data bits ignored
    wr(17'h1F555, 1, 16'hFFAA); wr(17'h0A2AA, 0, 16'h3355); wr(17'h1D555, 0, 16'h12A0);
    wr(17'h00042, 0, 16'h0F0F);
    chk("R6 high bits prog", pv, 6'b010000);
    chk("R6 data kept", cmd_data, 16'h0F0F);
    busy_pulse();

    // R2 identification
    keys(0); wr(17'h00555, 0, 16'h0090);
    chk("R2 mode", mode_o, 1);
    rd(17'h1F000);
    chk("R2 valid", id_valid, 1);
    chk("R2 mfr", id_data, 16'h0020);
    rd(17'h05AB1 & 17'h1FFFD);
    chk("R2 dev", id_data, DEV);
    rd(17'h00003);
    chk("R2 code11", id_data, 0);
    for (int b = 0; b < 32; b++) begin
      rd((ADDR_W'(b) << 12) | ADDR_W'((b * 37) & 32'hFFC) | 17'h2);
      chk("R2 prot", id_data, int'(PROT[b]));
    end
    // R3 single reset leaves identification
    wr(17'h01234, 0, 16'h00F0);
    chk("R3 single reset", pv, 6'b100000);
    chk("R3 mode", mode_o, 0);
    rd(17'h0);
    chk("R2 no answer outside", id_valid, 0);
    // R3 keyed reset
    keys(0); wr(17'h0ABCD, 0, 16'h00F0);
    chk("R3 keyed reset", pv, 6'b100000);

    // R5 sweep of first-write data bytes
    for (int d = 0; d < 256; d++) begin
      if (d != 'hAA && d != 'hF0) begin
        wr(17'h00555, 0, 16'(d));
        chk("R5 sweep pulse", pv, 0);
        chk("R5 sweep mode", mode_o, 0);
      end
    end
    keys(0); wr(17'h00555, 0, 16'h0091);
    chk("R5 bad code", mode_o, 0);
    keys(0); wr(17'h00555, 0, 16'h0090); wr(17'h00555, 0, 16'h0011);
    chk("R5 leave asel", mode_o, 0);
    keys(0); wr(17'h00555, 0, 16'h0080); wr(17'h00555, 0, 16'h00AA); wr(17'h00555, 0, 16'h0055);
    chk("R5 bad second key", mode_o, 0);
    wr(17'h00555, 0, 16'h0010);
    chk("R5 no chip", pv, 0);

    // R4 chip erase
    keys(0); wr(17'h00555, 0, 16'h0080); keys(0); wr(17'h00555, 0, 16'h0010);
    chk("R4 chip", pv, 6'b001000);
    chk("R4 chip mode", mode_o, 3);
    busy_pulse();
    chk("R4 chip done", mode_o, 0);

    // R4 block erase
    keys(0); wr(17'h00555, 0, 16'h0080); keys(0); wr(17'h0C000, 0, 16'h0030);
    chk("R4 block", pv, 6'b000100);
    chk("R4 block addr", cmd_addr, 17'h0C000);
    chk("R4 block mode", mode_o, 4);
    // R8 filtering in block erase
    wr(17'h04000, 0, 16'h0030);
    chk("R8 extra block", pv, 6'b000100);
    chk("R8 extra addr", cmd_addr, 17'h04000);
    wr(17'h00555, 0, 16'h00AA);
    chk("R8 other ignored", pv, 0);
    chk("R8 still erase", mode_o, 4);
    wr(17'h0, 0, 16'h00B0);
    chk("R8 suspend", pv, 6'b000010);
    @(negedge clk); susp_i = 1'b1;
    @(negedge clk);
    chk("R8 suspended", mode_o, 5);

    // R9 program inside suspension
    keys(0); wr(17'h00555, 0, 16'h00A0); wr(17'h1A000, 0, 16'h0001);
    chk("R9 prog", pv, 6'b010000);
    busy_pulse();
    chk("R9 back to susp", mode_o, 5);
    keys(0); wr(17'h00555, 0, 16'h0080);
    chk("R9 erase rejected", pv, 0);
    chk("R9 stays susp", mode_o, 5);
    wr(17'h0, 0, 16'h00F0);
    chk("R3 reset in susp", mode_o, 5);
    susp_i = 1'b0;
    wr(17'h0, 0, 16'h0030);
    chk("R9 resume", pv, 6'b000001);
    chk("R9 resume mode", mode_o, 4);
    busy_pulse();
    chk("R8 erase end", mode_o, 0);
    keys(0); wr(17'h00555, 0, 16'h0080); keys(0); wr(17'h10000, 0, 16'h0030);
    wr(17'h0, 0, 16'h00F0);
    chk("R8 reset", pv, 6'b100000);
    chk("R8 reset mode", mode_o, 0);

    // R10 bypass
    keys(0); wr(17'h00555, 0, 16'h0020);
    chk("R10 enter", mode_o, 2);
    wr(17'h0, 0, 16'h00A0); wr(17'h00333, 0, 16'hC3C3);
    chk("R10 prog", pv, 6'b010000);
    chk("R10 data", cmd_data, 16'hC3C3);
    busy_pulse();
    chk("R10 back", mode_o, 2);
    wr(17'h0, 0, 16'h00F0);
    chk("R10 reset pulse", pv, 6'b100000);
    chk("R10 reset stays", mode_o, 2);
    wr(17'h0, 0, 16'h0055);
    chk("R10 other stays", mode_o, 2);
    wr(17'h0, 0, 16'h0090); wr(17'h0, 0, 16'h0000);
    chk("R10 exit", mode_o, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule